// File: doc/BRIEF.md
# DMA Channel Register Port

This block is the processor-facing register front end of a four-channel DMA engine. Software reaches it with single-cycle 8-bit reads and writes at sixteen offsets. Offsets 0x0 to 0x7 give byte-wide access to eight 16-bit registers: one base address and one base count for each channel. The other eight offsets carry the control, mask, mode and status functions, plus three write-only strobe commands.

All eight 16-bit registers share one byte pointer. The pointer is a two-state machine. `PTR_LO` is the state after reset and `PTR_HI` is the other state. Any read or write to offsets 0x0 to 0x7 moves `PTR_LO` to `PTR_HI` and moves `PTR_HI` to `PTR_LO`. A write to the pointer-clear offset 0xC returns the pointer from either state to `PTR_LO`. A write to the master-reset offset 0xD does the same. If no access of these kinds occurs, the state holds.

Writes to the 16-bit registers are also sent to the channel datapaths as load strobes. Each strobe carries the byte and a flag saying which half it fills. The block drives per-channel mode fields, mask bits and a global disable to the datapaths. Per-channel request and terminal-count inputs come back in and are reported through a status read. Terminal-count flags are sticky, and a status read clears them.

Top module: `dma_port_regs`

## Requirements
- R1: One pointer serves all eight 16-bit registers. An access to offsets 0x0 to 0x7 uses the low byte (bits 7:0) in `PTR_LO` and the high byte (bits 15:8) in `PTR_HI`, and each such read or write toggles the pointer, whichever of the eight registers it hits. Reading returns the stored byte.
- R2: A write of any value to offset 0xC puts the pointer in `PTR_LO`.
- R3: A write of any value to offset 0xD puts the pointer in `PTR_LO`, clears all terminal-count flags and sets all four mask bits.
- R4: A write of any value to offset 0xE clears all four mask bits.
- R5: A write to offset 0xA changes one mask bit. Bits 1:0 pick the channel, and bit 2 is the new mask value (1 masks, 0 unmasks).
- R6: A write to offset 0xF loads mask bits 3:0 from write bits 3:0 (bit n is channel n). A read of 0xF returns the mask in bits 3:0 and zeros in bits 7:4.
- R7: A read of offset 0x8 returns the live request inputs in bits 7:4 (channel 3 down to 0) and the sticky terminal-count flags in bits 3:0. A terminal-count input pulse sets its flag, and the read clears the flags.
- R8: A terminal-count pulse in the same cycle as a status read is not lost: its flag is set after the read.
- R9: A write to offset 0xB stores write bits 7:2 as the mode of the channel picked by bits 1:0. `ch_mode` gives channel n in bits 6n+5:6n, ordered as op mode (2 bits; 00 demand, 11 cascade), decrement, auto-initialize, transfer type (2 bits; 01 write memory, 10 read memory).
- R10: A write to offset 0x8 sets `global_off` to write bit 2.
- R11: Writes to offset 0x9 change no state. Reads of offset 0xD return zero and leave the pointer unchanged. Reads of 0x9 to 0xC and 0xE also return zero.
- R12: After reset all masks are set, the pointer is `PTR_LO`, the flags are clear, `global_off` is 0, and all modes are zero.
- R13: During a write to offset k in 0x0 to 0x7, exactly one strobe is high: `ld_addr[k/2]` for even k or `ld_cnt[k/2]` for odd k. `ld_hi` shows the pointer and `ld_byte` carries the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Port write in this cycle (takes priority over read) |
| rd_en | input | 1 | Port read in this cycle |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after the read |
| req_in | input | 4 | Live per-channel request inputs |
| tc_in | input | 4 | Per-channel terminal-count pulses |
| mask_out | output | 4 | Per-channel mask bits |
| global_off | output | 1 | Controller-wide disable |
| ch_mode | output | 24 | Packed per-channel mode fields |
| ld_addr | output | 4 | Base-address byte load strobes |
| ld_cnt | output | 4 | Base-count byte load strobes |
| ld_hi | output | 1 | Strobed byte is the high half |
| ld_byte | output | 8 | Byte to load |

## Verification
The bench builds the block with its default four channels and 8-bit data. With these values the whole sixteen-offset map and every channel-select code are in use, so random offsets reach every register, mask path and mode slot. The random stream interleaves 16-bit register accesses with pointer-clear and master-reset strobes, so the shared pointer is exercised from both states. Terminal-count pulses are random, and some land on the same cycle as a status read or a master reset.

// File: rtl/dmaport_pkg.sv
package dmaport_pkg;

    localparam int unsigned OFS_W       = 4;
    localparam int unsigned MODE_W      = 6;
    localparam int unsigned CMD_OFF_BIT = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_STAT_CMD = 4'h8,
        OFS_REQ      = 4'h9,
        OFS_SMASK    = 4'hA,
        OFS_MODE     = 4'hB,
        OFS_PTR_CLR  = 4'hC,
        OFS_MRST     = 4'hD,
        OFS_MASK_CLR = 4'hE,
        OFS_MMASK    = 4'hF
    } ofs_e;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_e;

    typedef struct packed {
        logic [1:0] op_mode;
        logic       down;
        logic       auto_ld;
        logic [1:0] xfer;
    } chmode_t;

endpackage

// File: rtl/byte_ptr_fsm.sv
module byte_ptr_fsm
    import dmaport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic rewind,
    output logic ptr_hi
);

    ptr_e cur_q;
    ptr_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= PTR_LO;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            PTR_LO: begin
                if (rewind)    nxt = PTR_LO;
                else if (step) nxt = PTR_HI;
            end
            PTR_HI: begin
                if (rewind)    nxt = PTR_LO;
                else if (step) nxt = PTR_LO;
            end
        endcase
    end

    always_comb begin
        ptr_hi = (cur_q == PTR_HI);
    end

endmodule

// File: rtl/mask_unit.sv
module mask_unit #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_single,
    input  logic           wr_multi,
    input  logic           clr_all,
    input  logic           set_all,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] mask_q
);

    localparam int SELW = $clog2(NCH);

    logic [SELW-1:0] sel;
    logic            sel_val;

    assign sel     = wdata[SELW-1:0];
    assign sel_val = wdata[SELW];

    always_ff @(posedge clk) begin
        if (!rst_n || set_all) begin
            mask_q <= '1;
        end else if (clr_all) begin
            mask_q <= '0;
        end else if (wr_multi) begin
            mask_q <= wdata[NCH-1:0];
        end else if (wr_single) begin
            mask_q[sel] <= sel_val;
        end
    end

endmodule

// File: rtl/status_unit.sv
module status_unit #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc_in,
    input  logic           rd_stat,
    input  logic           clr,
    output logic [NCH-1:0] tc_q
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tc_q <= '0;
        end else if (rd_stat) begin
            tc_q <= tc_in;
        end else begin
            tc_q <= tc_q | tc_in;
        end
    end

endmodule

// File: rtl/mode_bank.sv
module mode_bank
    import dmaport_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_mode,
    input  logic [DW-1:0]         wdata,
    output logic [NCH*MODE_W-1:0] modes
);

    localparam int SELW = $clog2(NCH);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chmode_t m_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_q <= '0;
            end else if (wr_mode && wdata[SELW-1:0] == SELW'(c)) begin
                m_q <= chmode_t'(wdata[DW-1:DW-MODE_W]);
            end
        end
        assign modes[c*MODE_W +: MODE_W] = m_q;
    end

endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
    import dmaport_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [OFS_W-1:0]      addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic [NCH-1:0]        req_in,
    input  logic [NCH-1:0]        tc_in,
    output logic [NCH-1:0]        mask_out,
    output logic                  global_off,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]        ld_addr,
    output logic [NCH-1:0]        ld_cnt,
    output logic                  ld_hi,
    output logic [DW-1:0]         ld_byte
);

    localparam int NREG = 2 * NCH;
    localparam int REGW = $clog2(NREG);
    localparam int RW   = 2 * DW;

    logic            wr_act, rd_act, hit_reg;
    logic [REGW-1:0] idx;
    logic            ptr_hi;
    logic [NCH-1:0]  tc_q;
    logic [RW-1:0]   base_q [NREG];
    logic [DW-1:0]   rdata_q;
    logic            off_q;

    assign wr_act  = wr_en;
    assign rd_act  = rd_en && !wr_en;
    assign hit_reg = (addr < OFS_W'(NREG));
    assign idx     = addr[REGW-1:0];

    byte_ptr_fsm u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   ((wr_act || rd_act) && hit_reg),
        .rewind (wr_act && (addr == OFS_PTR_CLR || addr == OFS_MRST)),
        .ptr_hi (ptr_hi)
    );

    mask_unit #(.NCH(NCH), .DW(DW)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_single (wr_act && addr == OFS_SMASK),
        .wr_multi  (wr_act && addr == OFS_MMASK),
        .clr_all   (wr_act && addr == OFS_MASK_CLR),
        .set_all   (wr_act && addr == OFS_MRST),
        .wdata     (wdata),
        .mask_q    (mask_out)
    );

    status_unit #(.NCH(NCH)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .tc_in   (tc_in),
        .rd_stat (rd_act && addr == OFS_STAT_CMD),
        .clr     (wr_act && addr == OFS_MRST),
        .tc_q    (tc_q)
    );

    mode_bank #(.NCH(NCH), .DW(DW)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (wr_act && addr == OFS_MODE),
        .wdata   (wdata),
        .modes   (ch_mode)
    );

    // Base register storage, one 16-bit word per offset 0..NREG-1
    for (genvar r = 0; r < NREG; r++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[r] <= '0;
            end else if (wr_act && hit_reg && idx == REGW'(r)) begin
                if (ptr_hi) base_q[r][RW-1:DW] <= wdata;
                else        base_q[r][DW-1:0]  <= wdata;
            end
        end
    end

    // Load strobes toward the channel datapaths
    for (genvar c = 0; c < NCH; c++) begin : g_ld
        assign ld_addr[c] = wr_act && hit_reg && idx[REGW-1:1] == (REGW-1)'(c) && !idx[0];
        assign ld_cnt[c]  = wr_act && hit_reg && idx[REGW-1:1] == (REGW-1)'(c) &&  idx[0];
    end
    assign ld_hi   = ptr_hi;
    assign ld_byte = wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= 1'b0;
        end else if (wr_act && addr == OFS_STAT_CMD) begin
            off_q <= wdata[CMD_OFF_BIT];
        end
    end
    assign global_off = off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_act) begin
            if (hit_reg) begin
                rdata_q <= ptr_hi ? base_q[idx][RW-1:DW] : base_q[idx][DW-1:0];
            end else begin
                unique case (addr)
                    OFS_STAT_CMD: rdata_q <= DW'({req_in, tc_q});
                    OFS_MMASK:    rdata_q <= DW'(mask_out);
                    default:      rdata_q <= '0;
                endcase
            end
        end
    end
    assign rdata = rdata_q;

endmodule

// File: rtl/dma_port_regs_chk.sv
module dma_port_regs_chk
    import dmaport_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [OFS_W-1:0]      addr,
    input logic [DW-1:0]         wdata,
    input logic [DW-1:0]         rdata,
    input logic [NCH-1:0]        mask_out,
    input logic                  global_off,
    input logic [NCH-1:0]        ld_addr,
    input logic [NCH-1:0]        ld_cnt,
    input logic                  ld_hi
);

    // R13
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_addr, ld_cnt}));

    // R2
    ptr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_PTR_CLR) ##1 (wr_en && !addr[OFS_W-1]) |-> !ld_hi);

    // R3
    mrst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MRST) |=> (mask_out == '1));

    // R4
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MASK_CLR) |=> (mask_out == '0));

    // R6
    multi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MMASK) |=> (mask_out == $past(wdata[NCH-1:0])));

    // R10
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STAT_CMD) |=> (global_off == $past(wdata[CMD_OFF_BIT])));

    // R11
    mrst_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == OFS_MRST) |=> (rdata == '0));

endmodule

bind dma_port_regs dma_port_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/dma_port_regs_test.sv
module dma_port_regs_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [3:0]  req_in, tc_in;
    logic [3:0]  mask_out;
    logic        global_off;
    logic [23:0] ch_mode;
    logic [3:0]  ld_addr, ld_cnt;
    logic        ld_hi;
    logic [7:0]  ld_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    bit         m_ptr;
    logic [3:0] m_mask, m_tc;
    logic [5:0] m_mode [4];
    logic       m_off;
    logic [15:0] m_base [8];

    always #5 clk = ~clk;

    dma_port_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_in(req_in), .tc_in(tc_in),
        .mask_out(mask_out), .global_off(global_off), .ch_mode(ch_mode),
        .ld_addr(ld_addr), .ld_cnt(ld_cnt), .ld_hi(ld_hi), .ld_byte(ld_byte)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_modes();
        return {m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [3:0] rq);
        if (a < 8)        return m_ptr ? m_base[a[2:0]][15:8] : m_base[a[2:0]][7:0];
        else if (a == 8)  return {rq, m_tc};
        else if (a == 15) return {4'h0, m_mask};
        else              return 8'h00;
    endfunction

    function automatic string read_tag(input logic [3:0] a);
        if (a < 8)        return "R1";
        else if (a == 8)  return "R7";
        else if (a == 15) return "R6";
        else              return "R11";
    endfunction

    task automatic model_update(input bit w, input logic [3:0] a, input logic [7:0] d,
                                input logic [3:0] tcp);
        if (w && a == 4'hD)      m_tc = 4'h0;
        else if (!w && a == 8)   m_tc = tcp;
        else                     m_tc = m_tc | tcp;
        if (w) begin
            if (a < 8) begin
                if (m_ptr) m_base[a[2:0]][15:8] = d;
                else       m_base[a[2:0]][7:0]  = d;
                m_ptr = !m_ptr;
            end
            case (a)
                4'h8: m_off = d[2];
                4'hA: m_mask[d[1:0]] = d[2];
                4'hB: m_mode[d[1:0]] = d[7:2];
                4'hC: m_ptr = 1'b0;
                4'hD: begin m_ptr = 1'b0; m_mask = 4'hF; end
                4'hE: m_mask = 4'h0;
                4'hF: m_mask = d[3:0];
                default: ;
            endcase
        end else if (a < 8) begin
            m_ptr = !m_ptr;
        end
    endtask

    task automatic do_op(input bit w, input logic [3:0] a, input logic [7:0] d,
                         input logic [3:0] tcp, input logic [3:0] rq);
        logic [7:0] er;
        string      tg;
        @(negedge clk);
        wr_en = w; rd_en = !w; addr = a; wdata = d; tc_in = tcp; req_in = rq;
        #1;
        if (w && a < 8) begin
            // R13 strobe decode and byte half
            cmp("R13", {ld_addr, ld_cnt, ld_hi, ld_byte},
                {(a[0] ? 4'h0 : 4'(1 << a[2:1])), (a[0] ? 4'(1 << a[2:1]) : 4'h0), m_ptr, d});
        end
        er = exp_read(a, rq);
        tg = read_tag(a);
        model_update(w, a, d, tcp);
        @(posedge clk);
        #2;
        wr_en = 0; rd_en = 0; tc_in = 4'h0;
        if (!w) cmp(tg, 32'(rdata), 32'(er));
        cmp("R5", 32'(mask_out), 32'(m_mask));
        cmp("R9", 32'(ch_mode), 32'(exp_modes()));
        cmp("R10", 32'(global_off), 32'(m_off));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; req_in = 0; tc_in = 0;
        m_ptr = 0; m_mask = 4'hF; m_tc = 0; m_off = 0;
        for (int i = 0; i < 4; i++) m_mode[i] = '0;
        for (int i = 0; i < 8; i++) m_base[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R12 reset state
        @(negedge clk);
        cmp("R12", 32'({mask_out, global_off, ch_mode}), 32'({4'hF, 1'b0, 24'h0}));
        do_op(0, 4'h8, 8'h00, 4'h0, 4'h5);      // R12 flags clear, R7 request bits live

        // R1 pointer shared across different registers
        do_op(1, 4'h0, 8'h11, 4'h0, 4'h0);      // low byte of reg 0
        do_op(1, 4'h3, 8'h22, 4'h0, 4'h0);      // high byte of reg 3
        do_op(1, 4'hC, 8'h00, 4'h0, 4'h0);      // R2
        do_op(0, 4'h0, 8'h00, 4'h0, 4'h0);      // R1 reads low of reg 0
        do_op(0, 4'h3, 8'h00, 4'h0, 4'h0);      // R1 reads high of reg 3
        // R2 rewind from PTR_HI
        do_op(1, 4'h6, 8'hA5, 4'h0, 4'h0);
        do_op(1, 4'hC, 8'hFF, 4'h0, 4'h0);
        do_op(1, 4'h7, 8'h5A, 4'h0, 4'h0);      // R13 expects ld_hi=0

        // R11 read of 0xD returns zero and does not move pointer
        do_op(0, 4'hD, 8'h00, 4'h0, 4'h0);
        do_op(1, 4'h2, 8'h33, 4'h0, 4'h0);      // pointer now HI -> ld_hi=1
        // R11 write to 0x9 changes nothing
        do_op(1, 4'h9, 8'hFF, 4'h0, 4'h0);
        do_op(1, 4'h4, 8'h44, 4'h0, 4'h0);

        // R4, R5, R6 masks
        do_op(1, 4'hE, 8'h00, 4'h0, 4'h0);
        do_op(1, 4'hA, 8'h06, 4'h0, 4'h0);      // R5 set ch2
        do_op(1, 4'hA, 8'h02, 4'h0, 4'h0);      // R5 clear ch2
        do_op(1, 4'hF, 8'hF9, 4'h0, 4'h0);      // R6
        do_op(0, 4'hF, 8'h00, 4'h0, 4'h0);      // R6 readback

        // R9 modes, R10 command
        do_op(1, 4'hB, 8'hC9, 4'h0, 4'h0);
        do_op(1, 4'hB, 8'h16, 4'h0, 4'h0);
        do_op(1, 4'h8, 8'h04, 4'h0, 4'h0);
        do_op(1, 4'h8, 8'hFB, 4'h0, 4'h0);

        // R7 sticky flags, R8 pulse during status read
        do_op(1, 4'h9, 8'h00, 4'h3, 4'h0);
        do_op(0, 4'h8, 8'h00, 4'h4, 4'hA);      // R8 shows 3, keeps 4
        do_op(0, 4'h8, 8'h00, 4'h0, 4'h0);      // R8 shows 4
        do_op(0, 4'h8, 8'h00, 4'h0, 4'h0);      // R7 cleared

        // R3 master reset
        do_op(1, 4'hE, 8'h00, 4'h8, 4'h0);
        do_op(1, 4'h1, 8'h77, 4'h0, 4'h0);
        do_op(1, 4'hD, 8'h00, 4'h0, 4'h0);
        do_op(0, 4'h8, 8'h00, 4'h0, 4'h0);      // R3 flags cleared
        do_op(1, 4'h1, 8'h88, 4'h0, 4'h0);      // R3 pointer low again

        // Random phase
        for (int k = 0; k < 600; k++) begin
            bit         w;
            logic [3:0] a;
            w = $urandom_range(0, 1) == 1;
            a = 4'($urandom_range(0, 15));
            do_op(w, a, 8'($urandom), 4'($urandom_range(0, 3) == 0 ? $urandom : 0),
                  4'($urandom));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule